// File: doc/BRIEF.md
# Hot-Insertion Bus Connection Controller

This block decides when the backplane segment and the card segment of a two-wire serial bus (SDA/SCL) may be joined. It runs on the system clock and sees the sampled line levels of both segments. It also takes a synchronous undervoltage-lockout flag, an enable input, and a stuck-bus flag from a separate timeout block. It drives a connection level that gates the analog switch between the segments, a precharge-enable flag, a ready flag, and a one-cycle clear pulse back to the stuck-bus timer.

Each segment is watched for two things: an idle period, in which both of its lines stay high for a parameter number of cycles, and a stop condition, in which SDA rises while SCL is high. The segments are joined only when both sides are idle, or when one side produces a stop while the other side is idle. A stuck-bus report breaks the link. A fresh rising edge on enable after such a report forces the link closed again at once and clears the stuck timer. All four bus inputs pass through two synchronizer flops before any edge is detected.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While `uvlo` is high, `link_on` and `ready` are 0, `precharge_en` is 1, and no bus activity causes a connection.
- R2: With `enable` high and no stuck report, the segments are joined once both sides are idle.
- R3: A side is idle only after both of its lines have been high for `IDLE_CYC` consecutive cycles. No idle-based join occurs earlier than that after lockout clears or enable rises.
- R4: `precharge_en` drops when the first connection is made and stays low until `uvlo` is asserted again.
- R5: `enable` low forces `link_on` and `ready` to 0 combinationally in the same cycle, and keeps them 0 for as long as it stays low.
- R6: When `enable` returns high with no stuck report pending, no connection is made until the stop/idle qualification is met again.
- R7: `ready` is 1 exactly when `enable` is high and the segments are connected, and 0 during lockout, while disabled, and after a stuck-bus disconnect.
- R8: A stop on one side (SDA 0 to 1 while SCL is 1) joins the segments within 6 cycles if the other side is idle. An SDA rise while SCL is 0 is not a stop. A stop while the other side is busy does not join.
- R9: A rising edge on `stuck_fault` breaks the link within 3 cycles. No join happens while `stuck_fault` stays high. Once it clears, the normal qualification joins the segments again.
- R10: A rising edge on `enable` after a stuck report forces `link_on` to 1 within 3 cycles, even while `stuck_fault` is still high, and emits exactly one one-cycle `tmr_clr` pulse. An enable rise with no stuck report pending emits no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_sda | input | 1 | Backplane data line level |
| bp_scl | input | 1 | Backplane clock line level |
| cd_sda | input | 1 | Card data line level |
| cd_scl | input | 1 | Card clock line level |
| uvlo | input | 1 | Undervoltage lockout, synchronous to clk |
| enable | input | 1 | Connection enable |
| stuck_fault | input | 1 | Stuck-bus report from the timeout block |
| link_on | output | 1 | Segments connected |
| precharge_en | output | 1 | Precharge circuitry enable |
| ready | output | 1 | Connected and enabled |
| tmr_clr | output | 1 | One-cycle clear pulse to the stuck timer |

## Verification
The hardest state to reach is a forced connection made while the stuck report is still held high. The bench must first connect normally, then raise `stuck_fault`, then confirm that an idle bus alone does not reconnect. Only then does it toggle `enable` low and back high while `stuck_fault` stays asserted. Stop-versus-idle joins are told apart by timing: a stop must connect far sooner than `IDLE_CYC`, so the bench holds one side busy long enough that only the stop path can explain a connection within a few cycles.

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl #(
  parameter int IDLE_CYC = 9500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bp_sda,
  input  logic bp_scl,
  input  logic cd_sda,
  input  logic cd_scl,
  input  logic uvlo,
  input  logic enable,
  input  logic stuck_fault,
  output logic link_on,
  output logic precharge_en,
  output logic ready,
  output logic tmr_clr
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_CYC);

  // bit order: 3 bp_sda, 2 bp_scl, 1 cd_sda, 0 cd_scl
  logic [3:0] s1, s2, s3;
  logic [CW-1:0] bp_cnt, cd_cnt;
  logic link_q, pc_q, fault_q, en_q, sf_q, clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= {bp_sda, bp_scl, cd_sda, cd_scl};
      s2 <= s1;
      s3 <= s2;
    end
  end

  wire bp_high = s2[3] & s2[2];
  wire cd_high = s2[1] & s2[0];
  wire bp_stop = s2[3] & ~s3[3] & s2[2] & s3[2];
  wire cd_stop = s2[1] & ~s3[1] & s2[0] & s3[0];
  wire bp_idle = (bp_cnt == IDLE_MAX);
  wire cd_idle = (cd_cnt == IDLE_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || uvlo || !enable) begin
      bp_cnt <= '0;
      cd_cnt <= '0;
    end else begin
      bp_cnt <= !bp_high ? '0 : (bp_idle ? bp_cnt : bp_cnt + 1'b1);
      cd_cnt <= !cd_high ? '0 : (cd_idle ? cd_cnt : cd_cnt + 1'b1);
    end
  end

  wire en_rise = enable & ~en_q;
  wire sf_rise = stuck_fault & ~sf_q;
  wire force_c = en_rise & fault_q;
  wire join_ok = enable & ~link_q & ~stuck_fault &
                 ((bp_idle & cd_idle) | (bp_stop & cd_idle) | (cd_stop & bp_idle));

  always_ff @(posedge clk) begin
    if (!rst_n || uvlo) begin
      link_q  <= 1'b0;
      pc_q    <= 1'b1;
      fault_q <= 1'b0;
      en_q    <= 1'b0;
      sf_q    <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      en_q  <= enable;
      sf_q  <= stuck_fault;
      clr_q <= 1'b0;
      if (force_c) begin
        link_q  <= 1'b1;
        pc_q    <= 1'b0;
        fault_q <= 1'b0;
        clr_q   <= 1'b1;
      end else if (sf_rise) begin
        link_q  <= 1'b0;
        fault_q <= 1'b1;
      end else if (!enable) begin
        link_q <= 1'b0;
      end else if (join_ok) begin
        link_q  <= 1'b1;
        pc_q    <= 1'b0;
        fault_q <= 1'b0;
      end
    end
  end

  assign link_on      = link_q & enable & ~uvlo;
  assign ready        = link_on;
  assign precharge_en = pc_q | uvlo;
  assign tmr_clr      = clr_q;
endmodule

// File: rtl/hotswap_link_ctrl_chk.sv
module hotswap_link_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic uvlo,
  input logic enable,
  input logic stuck_fault,
  input logic link_on,
  input logic precharge_en,
  input logic ready,
  input logic tmr_clr
);
  // R1
  uvlo_isolates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |-> (!link_on && !ready));
  // R1
  uvlo_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> precharge_en);
  // R4
  precharge_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!precharge_en && !uvlo) |=> (!precharge_en || uvlo));
  // R5
  disable_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!ready && !link_on));
  // R7
  ready_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (enable && link_on));
  // R9
  stuck_breaks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stuck_fault) && $stable(enable)) |=> !link_on);
  // R10
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> !tmr_clr);
  // R10
  clr_with_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clr && enable && !uvlo) |-> link_on);
endmodule

bind hotswap_link_ctrl hotswap_link_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .enable(enable),
  .stuck_fault(stuck_fault), .link_on(link_on), .precharge_en(precharge_en),
  .ready(ready), .tmr_clr(tmr_clr)
);

// File: tb/hotswap_link_ctrl_tb_top.sv
module hotswap_link_ctrl_tb_top;
  localparam int CLK_PER = 10;
  localparam int IDLE = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bp_sda = 1'b1, bp_scl = 1'b1, cd_sda = 1'b1, cd_scl = 1'b1;
  logic uvlo = 1'b1, enable = 1'b1, stuck_fault = 1'b0;
  logic link_on, precharge_en, ready, tmr_clr;
  int checks = 0, fails = 0, clr_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  hotswap_link_ctrl #(.IDLE_CYC(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bp_sda(bp_sda), .bp_scl(bp_scl),
    .cd_sda(cd_sda), .cd_scl(cd_scl), .uvlo(uvlo), .enable(enable),
    .stuck_fault(stuck_fault), .link_on(link_on), .precharge_en(precharge_en),
    .ready(ready), .tmr_clr(tmr_clr)
  );

  always @(negedge clk) if (rst_n && tmr_clr) clr_cnt++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1", "link after reset", link_on, 0);
    chk("R1", "precharge after reset", precharge_en, 1);
    chk("R7", "ready after reset", ready, 0);
    chk("R10", "clr after reset", tmr_clr, 0);
  endtask

  task automatic t_uvlo_hold;
    wait_cyc(IDLE + 20);
    chk("R1", "link in lockout with idle bus", link_on, 0);
    chk("R1", "precharge in lockout", precharge_en, 1);
  endtask

  task automatic t_idle_join;
    uvlo = 1'b0;
    wait_cyc(IDLE - 2);
    chk("R3", "link before idle time", link_on, 0);
    wait_cyc(10);
    chk("R2", "link after both idle", link_on, 1);
    chk("R7", "ready when connected", ready, 1);
    chk("R4", "precharge off after join", precharge_en, 0);
  endtask

  task automatic t_enable;
    int c0;
    c0 = clr_cnt;
    enable = 1'b0;
    #1;
    chk("R5", "link same cycle enable low", link_on, 0);
    chk("R5", "ready same cycle enable low", ready, 0);
    wait_cyc(IDLE + 20);
    chk("R5", "link held off while disabled", link_on, 0);
    enable = 1'b1;
    wait_cyc(3);
    chk("R6", "no immediate join on enable", link_on, 0);
    wait_cyc(IDLE + 6);
    chk("R6", "join after requalification", link_on, 1);
    chk("R4", "precharge stays off", precharge_en, 0);
    chk("R10", "no clr pulse without fault", clr_cnt - c0, 0);
  endtask

  task automatic t_stop_join;
    enable = 1'b0;
    cd_sda = 1'b0;
    wait_cyc(2);
    enable = 1'b1;
    wait_cyc(IDLE + 10);
    chk("R8", "card busy, no join", link_on, 0);
    cd_scl = 1'b0;
    wait_cyc(5);
    cd_sda = 1'b1;
    wait_cyc(6);
    chk("R8", "sda rise with scl low is not stop", link_on, 0);
    cd_sda = 1'b0;
    wait_cyc(3);
    cd_scl = 1'b1;
    wait_cyc(10);
    cd_sda = 1'b1;
    wait_cyc(6);
    chk("R8", "stop with other side idle joins", link_on, 1);
  endtask

  task automatic t_both_busy;
    enable = 1'b0;
    bp_sda = 1'b0;
    wait_cyc(2);
    enable = 1'b1;
    wait_cyc(IDLE + 10);
    cd_sda = 1'b0;
    wait_cyc(10);
    cd_sda = 1'b1;
    wait_cyc(6);
    chk("R8", "stop with other side busy", link_on, 0);
    wait_cyc(IDLE + 10);
    chk("R8", "still no join while backplane low", link_on, 0);
    bp_sda = 1'b1;
    wait_cyc(IDLE + 8);
    chk("R2", "join once backplane idles", link_on, 1);
  endtask

  task automatic t_stuck_force;
    int c0;
    stuck_fault = 1'b1;
    wait_cyc(3);
    chk("R9", "stuck report breaks link", link_on, 0);
    chk("R7", "ready low after stuck", ready, 0);
    wait_cyc(IDLE + 20);
    chk("R9", "no join while stuck held", link_on, 0);
    c0 = clr_cnt;
    enable = 1'b0;
    wait_cyc(2);
    enable = 1'b1;
    wait_cyc(3);
    chk("R10", "forced join despite stuck", link_on, 1);
    chk("R10", "one clr pulse", clr_cnt - c0, 1);
    stuck_fault = 1'b0;
    wait_cyc(5);
    chk("R10", "stays connected after clear", link_on, 1);
  endtask

  task automatic t_stuck_resume;
    stuck_fault = 1'b1;
    wait_cyc(3);
    chk("R9", "second stuck breaks link", link_on, 0);
    stuck_fault = 1'b0;
    wait_cyc(IDLE + 8);
    chk("R9", "rejoin after stuck clears", link_on, 1);
  endtask

  task automatic t_uvlo_again;
    uvlo = 1'b1;
    #1;
    chk("R1", "lockout breaks link", link_on, 0);
    wait_cyc(2);
    chk("R4", "precharge back on in lockout", precharge_en, 1);
    chk("R7", "ready low in lockout", ready, 0);
  endtask

  initial begin
    wait_cyc(150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_uvlo_hold();
    t_idle_join();
    t_enable();
    t_stop_join();
    t_both_busy();
    t_stuck_force();
    t_stuck_resume();
    t_uvlo_again();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule